// File: doc/BRIEF.md
# Cascaded One-Hot Ring Frequency Divider

This block divides a base clock by a large fixed ratio. It does not use a wide binary counter and comparator. It uses a chain of short rotating rings. Each ring holds a single one that moves one position per advance. The first ring advances on every clock. Each later ring advances only in the one cycle where the ring before it reports a tick. The overall ratio is therefore the product of the ring lengths. For example, six rings of 25, 25, 20, 20, 20 and 20 positions give a ratio of one hundred million. Two rings of 17 and 15 positions give 255. Any ratio whose factors all lie between 2 and 32 can be built this way.

A ring that only advances on enable keeps its tap bit high across many base cycles. Each stage therefore qualifies its tap with its own enable, and what it passes on is a tick exactly one base cycle wide. The final stage's tick goes through one output flop. The result is a registered single-cycle, active-high pulse once per full period. It is meant for use as a clock enable downstream. The per-stage ticks are also brought out, which gives intermediate rates for free.

Ring lengths are fixed at elaboration through a parameter array. Elaboration stops with an error if there are no stages, or if any length is below 2 or above 32. A synchronous reset reloads every ring to its starting position. The first output pulse then comes exactly one full ratio after reset is released.

Top module: `ringdiv_top`

## Requirements
- R1: Let k be the number of rising clock edges at which rst_i was sampled low since it was last sampled high. With P the product of all stage lengths, pulse_o is high in exactly the cycles that follow edge counts k = P, 2P, 3P and so on. The first pulse therefore comes exactly P cycles after reset is released.
- R2: pulse_o is never high in two consecutive cycles. Each output pulse lasts one base clock cycle.
- R3: Let N0 be the length of stage 0. stage_tick_o[0] is high exactly when k mod N0 equals N0-1, so it gives one single-cycle tick every N0 cycles.
- R4: Let Pj be the product of the lengths of stages 0 through j. For each stage j of 1 or more, stage_tick_o[j] is high exactly when k mod Pj equals Pj-1. It is never high in a cycle where stage_tick_o[j-1] is low.
- R5: pulse_o is the last stage's tick delayed by one clock cycle through a flop. In any cycle whose previous edge was not a reset edge, pulse_o equals the value stage_tick_o[NUM_STAGES-1] had in the previous cycle.
- R6: At a rising edge with rst_i high, every ring returns to its start position. pulse_o and all bits of stage_tick_o are then low. When rst_i is asserted in the middle of a period, the count restarts, and the next pulse comes a full P cycles after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_i | input | 1 | Synchronous reset, active high |
| stage_tick_o | output | NUM_STAGES | Single-cycle tick of each stage, bit j for stage j |
| pulse_o | output | 1 | Registered single-cycle divided pulse, once per product of lengths |

## Verification
The hardest situation to reach is an exact period boundary on the slow stages, and especially the rollover of the last ring. That event happens only once every full product of cycles, and only when every earlier ring reaches its tap in the same cycle. The bench uses a small configuration with lengths 3, 2 and 32, which covers both limits of the legal range. It runs several full periods so that the 32-long last ring wraps repeatedly. A reset is then asserted at a point that is not a period boundary, which shows that a half-finished count is discarded and a full period follows. Expected pulse positions come from the bench's own product arithmetic. They are queued before each run and matched cycle by cycle against the output.

// File: rtl/ringdiv_pkg.sv
package ringdiv_pkg;

  localparam int unsigned RING_MIN = 2;
  localparam int unsigned RING_MAX = 32;

  // Legal ring length check used at elaboration.
  function automatic bit len_ok(input int n);
    return (n >= int'(RING_MIN)) && (n <= int'(RING_MAX));
  endfunction

  // Position of the tap bit inside a ring of length n.
  function automatic int tap_pos(input int n);
    return n - 1;
  endfunction

  // Start pattern: the single one sits at bit 0, so it takes n-1 advances
  // to reach the tap and the n-th advance produces the tick.
  function automatic logic [RING_MAX-1:0] seed_word();
    logic [RING_MAX-1:0] w;
    w = '0;
    w[0] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/ringdiv_ring.sv
module ringdiv_ring #(
  parameter int LEN = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic adv_i,
  output logic tap_o
);
  import ringdiv_pkg::*;

  localparam int TAP = tap_pos(LEN);
  localparam logic [RING_MAX-1:0] SEED_W = seed_word();
  localparam logic [LEN-1:0] SEED = SEED_W[LEN-1:0];

  logic [LEN-1:0] ring_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ring_q <= SEED;
    end else if (adv_i) begin
      ring_q <= {ring_q[LEN-2:0], ring_q[LEN-1]};
    end
  end

  assign tap_o = ring_q[TAP];

endmodule

// File: rtl/ringdiv_stage.sv
module ringdiv_stage #(
  parameter int LEN = 4
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  output logic tick_o
);

  logic tap;

  ringdiv_ring #(.LEN(LEN)) u_ring (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .adv_i (en_i),
    .tap_o (tap)
  );

  // The tap stays high across many base cycles while the stage waits for
  // its next enable; gating with the enable narrows it to one cycle.
  assign tick_o = tap & en_i;

endmodule

// File: rtl/ringdiv_outreg.sv
module ringdiv_outreg (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      q_o <= 1'b0;
    end else begin
      q_o <= d_i;
    end
  end

endmodule

// File: rtl/ringdiv_top.sv
module ringdiv_top #(
  parameter int NUM_STAGES = 6,
  parameter int STAGE_LEN [NUM_STAGES] = '{25, 25, 20, 20, 20, 20}
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  output logic [NUM_STAGES-1:0] stage_tick_o,
  output logic                  pulse_o
);
  import ringdiv_pkg::*;

  localparam int LAST = NUM_STAGES - 1;

  logic [NUM_STAGES-1:0] stage_en;
  logic [NUM_STAGES-1:0] stage_tick;
  logic                  final_tick;

  if (NUM_STAGES < 1) begin : g_bad_count
    $error("ringdiv_top: at least one stage is required");
  end

  for (genvar j = 0; j < NUM_STAGES; j++) begin : g_stage
    if (!len_ok(STAGE_LEN[j])) begin : g_bad_len
      $error("ringdiv_top: stage length out of range 2..32");
    end

    if (j == 0) begin : g_head
      assign stage_en[j] = 1'b1;
    end else begin : g_link
      assign stage_en[j] = stage_tick[j-1];
    end

    ringdiv_stage #(.LEN(STAGE_LEN[j])) u_stage (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .en_i   (stage_en[j]),
      .tick_o (stage_tick[j])
    );
  end

  assign final_tick   = stage_tick[LAST];
  assign stage_tick_o = stage_tick;

  ringdiv_outreg u_out (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (final_tick),
    .q_o   (pulse_o)
  );

endmodule

// File: rtl/ringdiv_chk.sv
module ringdiv_chk #(
  parameter int NUM_STAGES = 1,
  parameter int FIRST_LEN  = 2
) (
  input logic                  clk_i,
  input logic                  rst_i,
  input logic [NUM_STAGES-1:0] stage_tick_o,
  input logic                  final_tick,
  input logic                  pulse_o
);

  int head_cnt;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      head_cnt <= 0;
    end else if (head_cnt == FIRST_LEN - 1) begin
      head_cnt <= 0;
    end else begin
      head_cnt <= head_cnt + 1;
    end
  end

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o |=> !pulse_o); // R2

  AST_PULSE_REGISTERED: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> (pulse_o == $past(final_tick))); // R5

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    rst_i |=> (!pulse_o && (stage_tick_o == '0))); // R6

  AST_HEAD_PERIOD: assert property (@(posedge clk_i) disable iff (rst_i)
    stage_tick_o[0] == (head_cnt == FIRST_LEN - 1)); // R3

  for (genvar j = 1; j < NUM_STAGES; j++) begin : g_chain
    AST_TICK_NEEDS_PREV: assert property (@(posedge clk_i) disable iff (rst_i)
      stage_tick_o[j] |-> stage_tick_o[j-1]); // R4
  end

endmodule

bind ringdiv_top ringdiv_chk #(
  .NUM_STAGES (NUM_STAGES),
  .FIRST_LEN  (STAGE_LEN[0])
) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .stage_tick_o (stage_tick_o),
  .final_tick   (final_tick),
  .pulse_o      (pulse_o)
);

// File: tb/sim_ringdiv_top.sv
`timescale 1ns/1ps
module sim_ringdiv_top;

  localparam int NS = 3;
  localparam int LENS [NS] = '{3, 2, 32};
  localparam int WATCHDOG_CYCLES = 200000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] ticks;
  logic          pulse;

  int checks = 0;
  int fails  = 0;
  int k      = 0;
  logic rst_q = 1'b1;
  logic prev_rst = 1'b1;
  logic prev_last = 1'b0;
  logic mon_on = 1'b0;
  logic done = 1'b0;
  int unsigned exp_q[$];
  longint pp [NS];
  longint full;

  always #10 clk = ~clk;

  ringdiv_top #(.NUM_STAGES(NS), .STAGE_LEN(LENS)) u0 (
    .clk_i        (clk),
    .rst_i        (rst),
    .stage_tick_o (ticks),
    .pulse_o      (pulse)
  );

  // Prefix products, computed in the bench's own way.
  initial begin
    longint acc = 1;
    for (int j = 0; j < NS; j++) begin
      acc = acc * LENS[j];
      pp[j] = acc;
    end
    full = acc;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s k=%0d actual=%0d expected=%0d", req, k, act, exp);
    end
  endtask

  // Driver: queue the edge counts after which the pulse must appear.
  task automatic plan_pulses(input int n);
    for (int i = 1; i <= n; i++) exp_q.push_back(int'(full) * i);
  endtask

  always @(posedge clk) begin
    rst_q <= rst;
    k <= rst ? 0 : k + 1;
  end

  // Monitor
  initial begin
    @(posedge clk);
    mon_on = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_q) begin
        check(pulse == 1'b0, "R6 pulse in reset", pulse, 0);
        check(ticks == '0, "R6 ticks in reset", ticks, 0);
      end else begin
        for (int j = 0; j < NS; j++) begin
          bit e;
          e = ((k % pp[j]) == pp[j] - 1);
          if (j == 0) check(ticks[j] == e, "R3 stage0 tick", ticks[j], e);
          else        check(ticks[j] == e, "R4 stage tick", ticks[j], e);
        end
        if (exp_q.size() > 0 && k == int'(exp_q[0])) begin
          check(pulse == 1'b1, "R1 pulse due", pulse, 1);
          void'(exp_q.pop_front());
        end else begin
          check(pulse == 1'b0, "R2 pulse not due", pulse, 0);
        end
        if (!prev_rst) check(pulse == prev_last, "R5 registered output", pulse, prev_last);
      end
      prev_last = ticks[NS-1];
      prev_rst  = rst_q;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #3;
    plan_pulses(3);
    rst = 1'b0;
    repeat (3 * int'(full) + 10) @(posedge clk);
    #3;
    check(exp_q.size() == 0, "R1 all pulses seen", exp_q.size(), 0);
    // R6: reset mid-period, count must restart from a full period
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #3;
    exp_q.delete();
    plan_pulses(2);
    rst = 1'b0;
    repeat (2 * int'(full) + 10) @(posedge clk);
    #3;
    check(exp_q.size() == 0, "R6 pulses after restart", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule